// File: doc/BRIEF.md
# Parallel Flash Read Cycle Sequencer

This block runs single-byte read cycles on an asynchronous parallel NOR flash bus on behalf of a synchronous requester. A request carries an address and is accepted through a valid/ready handshake. The sequencer then drives the address and chip enable at once, and asserts output enable as late as the timing allows. It samples the data byte on the edge that ends the cycle and returns it with a one-cycle valid strobe. It then holds off the next cycle until the device outputs have had time to go back to high impedance.

Every device delay is a parameter in nanoseconds. The clock period is a parameter too. Each delay becomes a whole number of clock cycles by rounding the ratio up. The access length is the largest of the address-to-data, enable-to-data and output-enable-to-data counts. Output enable is placed so that its own delay ends on the same edge as the other two, which keeps the cycle no longer than the slowest path requires.

Top module: `flash_read_seq`

## Requirements
- R1: While reset is asserted and right after it is released: `fl_ce_n` = 1, `fl_oe_n` = 1, `rsp_valid` = 0 and `req_ready` = 1.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. From the next cycle, `fl_addr` carries the request address, `fl_ce_n` is 0 and `req_ready` is 0. With `req_valid` at 0, no cycle starts.
- R3: `fl_addr` does not change while `fl_ce_n` stays 0.
- R4: `fl_oe_n` is 0 only while `fl_ce_n` is 0. It falls `HOLD - OE` cycles after `fl_ce_n` falls and stays low for exactly `OE` cycles. Here `OE` = ceil(T_OE_NS / CLK_PERIOD_NS), with a minimum of 1.
- R5: `fl_ce_n` stays low for exactly `HOLD` cycles, where `HOLD` = max(ceil(T_ACC_NS/CLK_PERIOD_NS), ceil(T_CE_NS/CLK_PERIOD_NS), `OE`). Both enables rise on the same edge.
- R6: `rsp_valid` is 1 for exactly one cycle: the first cycle in which `fl_ce_n` is back at 1. In that cycle, `rsp_data` equals the value of `fl_dq` sampled on the edge that raised the enables.
- R7: After `fl_ce_n` rises, `req_ready` stays 0 for exactly `DF` = ceil(T_DF_NS/CLK_PERIOD_NS) cycles (minimum 1). The next fall of `fl_ce_n` therefore comes at least `DF + 1` cycles after the rise.
- R8: `rsp_data` keeps the last returned byte until the next response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_addr | input | ADDR_W | Byte address of the request |
| rsp_valid | output | 1 | One-cycle strobe: read data returned |
| rsp_data | output | DATA_W | Returned byte |
| fl_addr | output | ADDR_W | Address lines to the flash |
| fl_ce_n | output | 1 | Chip enable to the flash, active low |
| fl_oe_n | output | 1 | Output enable to the flash, active low |
| fl_dq | input | DATA_W | Data lines from the flash |

## Verification
The bench's bus model returns the inverted byte until every access delay has elapsed. A stale or wrongly sized cycle count therefore shows up at the port at once: the first response after it carries a bad byte, or the enables stay low for the wrong number of cycles. A state machine that leaves its float state early shows up within one request. `req_ready` rises too soon, and the model reports an enable falling while the previous data is still on the bus. A stuck state shows up within `HOLD + DF + 1` cycles, as a missing strobe or a ready that never returns.

// File: rtl/flash_rd_pkg.sv
`timescale 1ns/1ps
package flash_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_FLOAT  = 2'd2
    } seq_state_e;

    // Whole clock cycles covering a delay, rounded up.
    function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                                 input int unsigned clk_ns);
        return (t_ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/frs_cycle_timer.sv
`timescale 1ns/1ps
module frs_cycle_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CNT_W'(1);
        end else if (cnt_q != CNT_TOP) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

endmodule

// File: rtl/frs_ctrl.sv
`timescale 1ns/1ps
module frs_ctrl
    import flash_rd_pkg::*;
#(
    parameter int unsigned ADDR_W    = 18,
    parameter int unsigned CNT_W     = 4,
    parameter int unsigned HOLD_CYC  = 4,
    parameter int unsigned OE_START  = 2,
    parameter int unsigned FLOAT_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    input  logic [CNT_W-1:0]  count,
    output logic              cnt_start,
    output logic              capture,
    output logic [ADDR_W-1:0] fl_addr,
    output logic              fl_ce_n,
    output logic              fl_oe_n
);
    localparam bit               OE_AT_ACCEPT = (OE_START == 0);
    localparam logic [CNT_W-1:0] HOLD_C  = CNT_W'(HOLD_CYC);
    localparam logic [CNT_W-1:0] OE_C    = CNT_W'(OE_START);
    localparam logic [CNT_W-1:0] FLOAT_C = CNT_W'(FLOAT_CYC);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    typedef struct packed {
        seq_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic              ce_n;
        logic              oe_n;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        cnt_start = 1'b0;
        capture   = 1'b0;
        case (c_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    c_d.state = ST_ACCESS;
                    c_d.addr  = req_addr;
                    c_d.ce_n  = 1'b0;
                    c_d.oe_n  = !OE_AT_ACCEPT;
                    cnt_start = 1'b1;
                end
            end
            ST_ACCESS: begin
                if (!OE_AT_ACCEPT && count == OE_C) begin
                    c_d.oe_n = 1'b0;
                end
                if (count == HOLD_C) begin
                    capture   = 1'b1;
                    c_d.ce_n  = 1'b1;
                    c_d.oe_n  = 1'b1;
                    c_d.state = ST_FLOAT;
                    cnt_start = 1'b1;
                end
            end
            ST_FLOAT: begin
                if (count == FLOAT_C) begin
                    c_d.state = ST_IDLE;
                end
            end
            default: begin
                c_d.state = ST_IDLE;
                c_d.ce_n  = 1'b1;
                c_d.oe_n  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.state <= ST_IDLE;
            c_q.addr  <= '0;
            c_q.ce_n  <= 1'b1;
            c_q.oe_n  <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign req_ready = (c_q.state == ST_IDLE);
    assign fl_addr   = c_q.addr;
    assign fl_ce_n   = c_q.ce_n;
    assign fl_oe_n   = c_q.oe_n;

    // Observation counters for the window checks below.
    logic [CNT_W-1:0] ce_low_q, ce_high_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_low_q  <= '0;
            ce_high_q <= CNT_TOP;
        end else begin
            ce_low_q  <= fl_ce_n ? '0 : ((ce_low_q == CNT_TOP) ? ce_low_q : ce_low_q + CNT_W'(1));
            ce_high_q <= !fl_ce_n ? '0 : ((ce_high_q == CNT_TOP) ? ce_high_q : ce_high_q + CNT_W'(1));
        end
    end

    p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_ce_n |-> !req_ready);

    p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_ce_n && $past(!fl_ce_n)) |-> $stable(fl_addr));

    p_oe_inside_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> !fl_ce_n);

    p_ce_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_ce_n) |-> (ce_low_q == HOLD_C));

    p_float_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_ce_n) |-> (ce_high_q >= FLOAT_C));

endmodule

// File: rtl/frs_capture.sv
`timescale 1ns/1ps
module frs_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } cap_t;

    cap_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.valid = capture;
        if (capture) r_d.data = bus_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rsp_valid = r_q.valid;
    assign rsp_data  = r_q.data;

    p_single_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rsp_valid && $past(rst_n)) |-> $stable(rsp_data));

endmodule

// File: rtl/flash_read_seq.sv
`timescale 1ns/1ps
module flash_read_seq
    import flash_rd_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 20,
    parameter int unsigned T_ACC_NS      = 70,
    parameter int unsigned T_CE_NS       = 70,
    parameter int unsigned T_OE_NS       = 35,
    parameter int unsigned T_DF_NS       = 25,
    parameter int unsigned ADDR_W        = 18,
    parameter int unsigned DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] fl_addr,
    output logic              fl_ce_n,
    output logic              fl_oe_n,
    input  logic [DATA_W-1:0] fl_dq
);
    localparam int unsigned ACC_CYC   = ns_to_cycles(T_ACC_NS, CLK_PERIOD_NS);
    localparam int unsigned CE_CYC    = ns_to_cycles(T_CE_NS, CLK_PERIOD_NS);
    localparam int unsigned OE_CYC    = max_u(ns_to_cycles(T_OE_NS, CLK_PERIOD_NS), 1);
    localparam int unsigned HOLD_CYC  = max_u(max_u(ACC_CYC, CE_CYC), OE_CYC);
    localparam int unsigned OE_START  = HOLD_CYC - OE_CYC;
    localparam int unsigned FLOAT_CYC = max_u(ns_to_cycles(T_DF_NS, CLK_PERIOD_NS), 1);
    localparam int unsigned CNT_W     = $clog2(max_u(HOLD_CYC, FLOAT_CYC) + 1) + 1;

    logic [CNT_W-1:0] count;
    logic             cnt_start;
    logic             capture;

    frs_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (cnt_start),
        .count (count)
    );

    frs_ctrl #(
        .ADDR_W    (ADDR_W),
        .CNT_W     (CNT_W),
        .HOLD_CYC  (HOLD_CYC),
        .OE_START  (OE_START),
        .FLOAT_CYC (FLOAT_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_ready (req_ready),
        .count     (count),
        .cnt_start (cnt_start),
        .capture   (capture),
        .fl_addr   (fl_addr),
        .fl_ce_n   (fl_ce_n),
        .fl_oe_n   (fl_oe_n)
    );

    frs_capture #(.DATA_W(DATA_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .bus_data  (fl_dq),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

endmodule

// File: tb/flash_read_seq_bench.sv
`timescale 1ns/1ps
module flash_read_seq_bench;
    localparam int CLK_NS = 20;
    localparam int ACC_NS = 90;
    localparam int CE_NS  = 70;
    localparam int OE_NS  = 35;
    localparam int DF_NS  = 25;
    localparam int AW = 18;
    localparam int DW = 8;

    // Expected cycle counts from the requirements (ceil of ratio).
    localparam int ACC_C  = (ACC_NS + CLK_NS - 1) / CLK_NS;
    localparam int CE_C   = (CE_NS + CLK_NS - 1) / CLK_NS;
    localparam int OE_C0  = (OE_NS + CLK_NS - 1) / CLK_NS;
    localparam int OE_C   = (OE_C0 < 1) ? 1 : OE_C0;
    localparam int HOLD_A = (ACC_C > CE_C) ? ACC_C : CE_C;
    localparam int HOLD_C = (HOLD_A > OE_C) ? HOLD_A : OE_C;
    localparam int DF_C0  = (DF_NS + CLK_NS - 1) / CLK_NS;
    localparam int DF_C   = (DF_C0 < 1) ? 1 : DF_C0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [AW-1:0] req_addr = '0;
    logic rsp_valid;
    logic [DW-1:0] rsp_data;
    logic [AW-1:0] fl_addr;
    logic fl_ce_n, fl_oe_n;
    logic [DW-1:0] fl_dq = '0;

    int checks = 0;
    int fails = 0;
    logic [DW-1:0] exp_q[$];
    logic [DW-1:0] last_data = '0;
    bit done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    flash_read_seq #(
        .CLK_PERIOD_NS(CLK_NS), .T_ACC_NS(ACC_NS), .T_CE_NS(CE_NS),
        .T_OE_NS(OE_NS), .T_DF_NS(DF_NS), .ADDR_W(AW), .DATA_W(DW)
    ) u_flash_read_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .fl_addr(fl_addr), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_dq(fl_dq)
    );

    function automatic logic [DW-1:0] mem_byte(input logic [AW-1:0] a);
        return a[7:0] ^ {a[15:10], a[17:16]} ^ 8'h3C;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural flash: wrong data until all delays have elapsed.
    time t_addr = 0, t_ce = 0, t_oe = 0, t_rel = 0;
    always @(fl_addr) t_addr = $time;
    always @(negedge fl_ce_n) begin
        t_ce = $time;
        if (rst_n && $time < t_rel + DF_NS) chk(1'b0, "R7 bus overlap", 32'($time), 32'(t_rel + DF_NS));
    end
    always @(negedge fl_oe_n) t_oe = $time;
    always @(posedge fl_ce_n or posedge fl_oe_n) t_rel = $time;
    always begin
        #1;
        if (!fl_ce_n && !fl_oe_n && $time >= t_addr + ACC_NS &&
            $time >= t_ce + CE_NS && $time >= t_oe + OE_NS)
            fl_dq = mem_byte(fl_addr);
        else
            fl_dq = ~mem_byte(fl_addr);
    end

    // Monitor and scoreboard.
    int ce_low = 0, oe_low = 0, oe_first = 0, ce_high = 100, rdy_low = 0;
    bit prev_ce = 1'b1, rdy_done = 1'b1;
    logic [AW-1:0] addr_at_fall = '0;
    bit addr_moved = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid) begin
                chk(prev_ce == 1'b0 && fl_ce_n == 1'b1, "R6 strobe timing", 32'(fl_ce_n), 32'd1);
                if (exp_q.size() == 0) chk(1'b0, "R6 unexpected response", 32'(rsp_data), 32'd0);
                else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    chk(rsp_data == e, "R6 read data", 32'(rsp_data), 32'(e));
                    last_data = e;
                end
            end
            if (!fl_ce_n) begin
                if (prev_ce) begin
                    chk(ce_high >= DF_C + 1, "R7 gap before enable", 32'(ce_high), 32'(DF_C + 1));
                    chk(!req_ready, "R2 ready low in cycle", 32'(req_ready), 32'd0);
                    addr_at_fall = fl_addr;
                    addr_moved = 1'b0;
                    ce_low = 0; oe_low = 0; oe_first = 0;
                end
                ce_low++;
                if (fl_addr != addr_at_fall) addr_moved = 1'b1;
                if (!fl_oe_n) begin
                    if (oe_low == 0) oe_first = ce_low;
                    oe_low++;
                end
            end else begin
                if (!prev_ce) begin
                    chk(ce_low == HOLD_C, "R5 enable width", 32'(ce_low), 32'(HOLD_C));
                    chk(oe_low == OE_C, "R4 output-enable width", 32'(oe_low), 32'(OE_C));
                    chk(oe_first == HOLD_C - OE_C + 1, "R4 output-enable offset", 32'(oe_first), 32'(HOLD_C - OE_C + 1));
                    chk(!addr_moved, "R3 address stable", 32'(addr_moved), 32'd0);
                    chk(fl_oe_n, "R4 oe released with ce", 32'(fl_oe_n), 32'd1);
                    ce_high = 0; rdy_low = 0; rdy_done = 1'b0;
                end
                ce_high++;
                if (!rdy_done) begin
                    if (!req_ready) rdy_low++;
                    else begin
                        chk(rdy_low == DF_C, "R7 ready low after float", 32'(rdy_low), 32'(DF_C));
                        rdy_done = 1'b1;
                    end
                end
                if (!fl_oe_n) chk(1'b0, "R4 oe without ce", 32'(fl_oe_n), 32'd1);
            end
            prev_ce = fl_ce_n;
        end
    end

    task automatic send(input logic [AW-1:0] a, input bit keep);
        req_valid = 1'b1;
        req_addr  = a;
        while (!req_ready) @(negedge clk);
        exp_q.push_back(mem_byte(a));
        @(negedge clk);
        chk(fl_addr == a, "R2 address driven", 32'(fl_addr), 32'(a));
        chk(!fl_ce_n, "R2 enable after accept", 32'(fl_ce_n), 32'd0);
        if (!keep) req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                chk(fl_ce_n && fl_oe_n && !rsp_valid && req_ready, "R1 reset outputs",
                    {fl_ce_n, fl_oe_n, rsp_valid, req_ready}, 32'b1101);
                rst_n = 1'b1;
                @(negedge clk);
                chk(fl_ce_n && fl_oe_n && !rsp_valid && req_ready, "R1 after release",
                    {fl_ce_n, fl_oe_n, rsp_valid, req_ready}, 32'b1101);
                idle(5);
                chk(fl_ce_n, "R2 no request no cycle", 32'(fl_ce_n), 32'd1);
                send(18'h00000, 1'b0); idle(12);
                send(18'h3FFFF, 1'b0); idle(12);
                send(18'h12345, 1'b0); idle(12);
                send(18'h15555, 1'b0); idle(3);
                for (int i = 0; i < 8; i++) send(18'(i * 18'h0A3B7 + 18'h00101), 1'b1);
                idle(12);
                for (int i = 0; i < 6; i++) begin
                    send(18'(18'h2AAAA ^ (i << 3)), 1'b0);
                    idle(i);
                end
                idle(20);
                chk(rsp_data == last_data, "R8 data held", 32'(rsp_data), 32'(last_data));
                chk(exp_q.size() == 0, "R6 all responses returned", 32'(exp_q.size()), 32'd0);
                done = 1'b1;
            end
            begin
                repeat (20000) @(posedge clk);
                if (!done) chk(1'b0, "watchdog", 32'd0, 32'd1);
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule